// File: doc/BRIEF.md
# Programmable System Clock Divider Unit

This block derives two clock-enable streams, a system enable and a main enable, from one of three oscillator sources. All logic runs on a single fast reference clock. Each source appears as a one-cycle tick input on that clock, and the outputs are one-cycle strobes on the same clock. No real clock is gated or muxed.

Software picks the source, sets a power-of-two system divide ratio and chooses whether the main enable runs at the system rate or at half of it. It does this through a small register port with two word offsets. A PLL power bit drives the PLL enable output. The block does not refuse the selection of a source that is not running. It applies the selection anyway and raises a sticky error flag. With no ticks arriving, the output strobes simply stop.

Top module: `sysclk_div_unit`

## Requirements
- R1: After reset, offset 0 reads source code 0 in bits [1:0], PLL power bit [2] = 0 and error bit [3] = 0. Offset 1 reads divide code 0 in bits [2:0] and main select bit [3] = 0. `pllEnable`, `sysEn` and `mainEn` are low.
- R2: Divide code c in offset 1 bits [2:0], for c from 0 to 5, makes `sysEn` pulse once every 2^c ticks of the selected source.
- R3: Divide codes 6 and 7 both give division by 1: one `sysEn` pulse per source tick.
- R4: Main select bit [3] of offset 1 set to 0 makes `mainEn` equal `sysEn`. Set to 1, `mainEn` pulses on every second `sysEn` pulse, starting with the second pulse after the last restart. `mainEn` is never high without `sysEn`.
- R5: A write that changes the source, the divide code or the main select restarts the divider. `sysEn` is low in the cycle after the write edge. With a tick on every cycle and ratio N, the first pulse appears N cycles after the write edge.
- R6: Source code 0 selects `hsTick`, code 1 selects `pllTick`, and codes 2 and 3 select `lsTick`. Offset 0 bits [1:0] read back the source in use. `sysEn` rises only in the cycle after a tick of the selected source.
- R7: PLL power bit [2] of offset 0 drives `pllEnable`. A write that would clear it is ignored for that bit while the resulting source is the PLL.
- R8: Selecting a source whose run flag is low still applies the selection and sets error bit [3] of offset 0. The error bit stays set until reset.
- R9: Register writes take effect at the write edge. Outputs are registered, so a strobe appears one cycle after the tick that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register word offset |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Read data for `addr`, combinational |
| hsTick | input | 1 | High-speed oscillator tick |
| pllTick | input | 1 | PLL output tick |
| lsTick | input | 1 | Low-speed oscillator tick |
| hsRun | input | 1 | High-speed oscillator running |
| pllRun | input | 1 | PLL running |
| lsRun | input | 1 | Low-speed oscillator running |
| sysEn | output | 1 | System clock enable strobe |
| mainEn | output | 1 | Main clock enable strobe |
| pllEnable | output | 1 | PLL power enable |

## Verification
The assertions assume that ticks and register writes arrive as single-cycle levels sampled on the reference clock edge. They also assume that a source can stay silent for any length of time, so no property ever requires a pulse to appear. The bench drives every input at the falling edge. It keeps the high-speed tick high on every cycle, toggles the PLL tick on alternate cycles and pulses the low-speed tick every fourth cycle. The pulse counts over 64-cycle windows therefore follow directly from the ratios.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;
  localparam int REG_W = 4;
  localparam int SRC_W = 2;
  localparam int DIV_W = 3;
  localparam int MAX_SHIFT = 5;

  localparam logic [SRC_W-1:0] SRC_HS  = 2'd0;
  localparam logic [SRC_W-1:0] SRC_PLL = 2'd1;

  typedef struct packed {
    logic             restart;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] divCode;
    logic             halfMain;
  } ctrlBus_t;
endpackage

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             hsRun,
  input  logic             pllRun,
  input  logic             lsRun,
  output logic             pllPower,
  output logic             errFlag,
  output ctrlBus_t         ctrlBus
);
  logic [SRC_W-1:0] srcQ;
  logic [DIV_W-1:0] codeQ;
  logic             mainQ;
  logic             powerQ;
  logic             errQ;
  logic [SRC_W-1:0] newSrc;
  logic             newRun;
  logic             changed;

  assign newSrc = wrData[SRC_W-1:0];

  always_comb begin
    case (newSrc)
      SRC_HS:  newRun = hsRun;
      SRC_PLL: newRun = pllRun;
      default: newRun = lsRun;
    endcase
  end

  always_comb begin
    if (addr == 1'b0) changed = (newSrc != srcQ);
    else changed = (wrData[DIV_W-1:0] != codeQ) || (wrData[3] != mainQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ   <= SRC_HS;
      codeQ  <= '0;
      mainQ  <= 1'b0;
      powerQ <= 1'b0;
      errQ   <= 1'b0;
    end else if (wrEn) begin
      if (addr == 1'b0) begin
        srcQ   <= newSrc;
        powerQ <= wrData[2] | ((newSrc == SRC_PLL) & powerQ);
        if (!newRun) errQ <= 1'b1;
      end else begin
        codeQ <= wrData[DIV_W-1:0];
        mainQ <= wrData[3];
      end
    end
  end

  always_comb begin
    if (addr == 1'b0) rdData = {errQ, powerQ, srcQ};
    else rdData = {mainQ, codeQ};
  end

  assign ctrlBus.restart  = wrEn & changed;
  assign ctrlBus.src      = srcQ;
  assign ctrlBus.divCode  = codeQ;
  assign ctrlBus.halfMain = mainQ;
  assign pllPower = powerQ;
  assign errFlag  = errQ;
endmodule

// File: rtl/sysclk_div_datapath.sv
module sysclk_div_datapath
  import sysclk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctrlBus_t ctrlBus,
  input  logic     hsTick,
  input  logic     pllTick,
  input  logic     lsTick,
  output logic     sysEn,
  output logic     mainEn
);
  localparam int CNT_W = MAX_SHIFT;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lastVal;
  logic [DIV_W-1:0] shift;
  logic             srcTick;
  logic             wrap;
  logic             halfQ;
  logic             sysQ;
  logic             mainQ;

  always_comb begin
    case (ctrlBus.src)
      SRC_HS:  srcTick = hsTick;
      SRC_PLL: srcTick = pllTick;
      default: srcTick = lsTick;
    endcase
  end

  assign shift   = (ctrlBus.divCode <= DIV_W'(MAX_SHIFT)) ? ctrlBus.divCode : '0;
  assign span    = (CNT_W+1)'(1) << shift;
  assign lastVal = CNT_W'(span - (CNT_W+1)'(1));
  assign wrap    = srcTick && (cntQ == lastVal);

  always_ff @(posedge clk) begin
    if (!rstN || ctrlBus.restart) begin
      cntQ  <= '0;
      halfQ <= 1'b0;
      sysQ  <= 1'b0;
      mainQ <= 1'b0;
    end else begin
      sysQ  <= wrap;
      mainQ <= wrap && (!ctrlBus.halfMain || halfQ);
      if (wrap) begin
        cntQ  <= '0;
        halfQ <= ~halfQ;
      end else if (srcTick) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  assign sysEn  = sysQ;
  assign mainEn = mainQ;
endmodule

// File: rtl/sysclk_div_unit.sv
module sysclk_div_unit
  import sysclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             hsTick,
  input  logic             pllTick,
  input  logic             lsTick,
  input  logic             hsRun,
  input  logic             pllRun,
  input  logic             lsRun,
  output logic             sysEn,
  output logic             mainEn,
  output logic             pllEnable
);
  ctrlBus_t ctrlBus;
  logic     errFlag;

  sysclk_div_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hsRun(hsRun), .pllRun(pllRun), .lsRun(lsRun),
    .pllPower(pllEnable), .errFlag(errFlag), .ctrlBus(ctrlBus)
  );

  sysclk_div_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus), .hsTick(hsTick),
    .pllTick(pllTick), .lsTick(lsTick), .sysEn(sysEn), .mainEn(mainEn)
  );
endmodule

// File: rtl/sysclk_div_checker.sv
module sysclk_div_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sysEn,
  input logic       mainEn,
  input logic       pllEnable,
  input logic       restart,
  input logic [1:0] srcSel,
  input logic       hsTick,
  input logic       pllTick,
  input logic       lsTick,
  input logic       errFlag
);
  AST_MAIN_WITH_SYS: assert property (@(posedge clk) disable iff (!rstN)
    mainEn |-> sysEn); // R4

  AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $past(restart) |-> !sysEn); // R5

  AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    sysEn |-> (($past(srcSel) == 2'd0) ? $past(hsTick) :
               ($past(srcSel) == 2'd1) ? $past(pllTick) : $past(lsTick))); // R6

  AST_PLL_KEPT_ON: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd1 && $past(srcSel) == 2'd1 && $past(pllEnable)) |-> pllEnable); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag); // R8
endmodule

bind sysclk_div_unit sysclk_div_checker u_chk (
  .clk(clk), .rstN(rstN), .sysEn(sysEn), .mainEn(mainEn),
  .pllEnable(pllEnable), .restart(ctrlBus.restart), .srcSel(ctrlBus.src),
  .hsTick(hsTick), .pllTick(pllTick), .lsTick(lsTick), .errFlag(errFlag)
);

// File: tb/sysclk_div_unit_bench.sv
module sysclk_div_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;
  logic       hsTick = 1'b1;
  logic       pllTick = 1'b0;
  logic       lsTick = 1'b0;
  logic       hsRun = 1'b1;
  logic       pllRun = 1'b1;
  logic       lsRun = 1'b0;
  logic       sysEn, mainEn, pllEnable;
  int         total = 0;
  int         bad = 0;
  int         lsPhase = 0;

  sysclk_div_unit u_sysclk_div_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hsTick(hsTick), .pllTick(pllTick), .lsTick(lsTick),
    .hsRun(hsRun), .pllRun(pllRun), .lsRun(lsRun), .sysEn(sysEn),
    .mainEn(mainEn), .pllEnable(pllEnable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    pllTick <= ~pllTick;
    lsPhase <= (lsPhase + 1) % 4;
    lsTick  <= (lsPhase == 3);
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [3:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [3:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic countPulses(output int sysCnt, output int mainCnt);
    sysCnt = 0; mainCnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (sysEn) sysCnt++;
      if (mainEn) mainCnt++;
    end
  endtask

  task automatic testReset();
    logic [3:0] d;
    readReg(1'b0, d); check("R1 offset0", d, 0);
    readReg(1'b1, d); check("R1 offset1", d, 0);
    check("R1 pllEnable", pllEnable, 0);
  endtask

  task automatic testRatios();
    int s, m;
    for (int c = 0; c <= 5; c++) begin
      writeReg(1'b1, 4'(c));
      repeat (40) @(negedge clk);
      countPulses(s, m);
      check($sformatf("R2 code %0d", c), s, 64 >> c);
      check($sformatf("R4 follow code %0d", c), m, 64 >> c);
    end
    writeReg(1'b1, 4'd6); countPulses(s, m); check("R3 code 6", s, 64);
    writeReg(1'b1, 4'd2);
    writeReg(1'b1, 4'd7); countPulses(s, m); check("R3 code 7", s, 64);
  endtask

  task automatic testHalfMain();
    int s, m;
    writeReg(1'b1, 4'b1001);
    countPulses(s, m);
    check("R4 sys rate", s, 32);
    check("R4 half main", m, 16);
  endtask

  task automatic testRestart();
    writeReg(1'b1, 4'd0);
    repeat (3) @(negedge clk);
    writeReg(1'b1, 4'd2);
    check("R5 quiet after write", sysEn, 0);
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk); @(negedge clk);
      check($sformatf("R5 R9 first pulse step %0d", i), sysEn, (i == 4) ? 1 : 0);
    end
  endtask

  task automatic testSources();
    logic [3:0] d;
    int s, m;
    writeReg(1'b1, 4'd0);
    writeReg(1'b0, 4'b0101);
    readReg(1'b0, d); check("R6 pll readback", d[1:0], 1);
    countPulses(s, m); check("R6 pll rate", s, 32);
    check("R7 pll on", pllEnable, 1);
    writeReg(1'b0, 4'b0001);
    readReg(1'b0, d); check("R7 clear ignored", d[2], 1);
    check("R7 pllEnable held", pllEnable, 1);
    check("R8 no error yet", d[3], 0);
    writeReg(1'b0, 4'b0010);
    readReg(1'b0, d);
    check("R8 error set", d[3], 1);
    check("R8 ls applied", d[1:0], 2);
    check("R7 cleared off pll", pllEnable, 0);
    writeReg(1'b1, 4'd1);
    countPulses(s, m); check("R6 ls rate", s, 8);
    hsTick = 1'b0;
    writeReg(1'b0, 4'd0);
    countPulses(s, m); check("R6 silent source", s, 0);
    hsTick = 1'b1;
    readReg(1'b0, d); check("R8 sticky", d[3], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sysEn reset", sysEn, 0);
    rstN = 1'b1;
    testReset();
    testRatios();
    testHalfMain();
    testRestart();
    testSources();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule